// File: doc/BRIEF.md
# Storage-Free Lane Transposer for a Row-Column Transform Engine

This block sits between the output of a systolic 1-D transform array and the input of its second pass. The array delivers each column of intermediate results as four lanes. Column t arrives diagonally rotated, so lane j carries the value of row (j+t) mod 4. The transposer rotates the lanes back so that output lane k carries row k of that column. In effect it emits the transposed block, one row of the transposed matrix per valid output cycle. It holds no block storage. A rotating selection network does the reordering, and short per-lane register chains align values when the array has fewer rows.

A single-bit mode splits the lanes into two independent halves, so that two small 2x2 blocks are transposed side by side. A two-bit row configuration tells the block how many rows of cells the array was built with. With fewer rows, the lanes of one column arrive over several input cycles. The lanes that arrive early are held back by bypassable delay stages until the last lane of the column is present. The array-side interface is the same in every configuration. The column sequencing restarts whenever the array raises its first-of-block flag.

Top module: `xpose_switch`

## Requirements
- R1: While rst_n is low and after it rises with no input, out_valid is 0 and out_lanes is all zeros.
- R2: With cfg_rows = 00 and mode_2x2 = 0, a block is four input cycles, t = 0..3. On cycle t, input lane j (bits j*DW +: DW) carries Y[(j+t) mod 4][t]. In the next cycle, out_valid is 1 and output lane k carries Y[k][t].
- R3: With mode_2x2 = 1 and cfg_rows = 00 or 01, lanes 0-1 carry 2x2 block A and lanes 2-3 carry 2x2 block B, over two cycles t = 0..1. Lane j<2 carries A[(j+t) mod 2][t] and lane j>=2 carries B[(j-2+t) mod 2][t]. The next cycle outputs A[k][t] on lane k<2 and B[k-2][t] on lane k>=2.
- R4: With cfg_rows = 01 (two rows) and mode_2x2 = 0, each column takes two input cycles. Lanes 0-1 are taken from the first cycle and lanes 2-3 from the second. Output appears only after the second cycle, and the lanes not taken in each cycle have no effect.
- R5: With cfg_rows = 10 (one row) and mode_2x2 = 0, each column takes four input cycles, and lane j is taken from sub-cycle j.
- R6: With cfg_rows = 10 and mode_2x2 = 1, each column takes two input cycles. Lanes 0 and 2 are taken from the first cycle and lanes 1 and 3 from the second.
- R7: cfg_rows = 11 behaves exactly like cfg_rows = 00.
- R8: An input cycle with in_valid and in_first is always sub-cycle 0 of column 0, even when a previous block was left incomplete.
- R9: After the last column of a block, sequencing wraps to column 0 without in_first. This happens after four columns in 4x4 mode and after two columns in 2x2 mode.
- R10: Cycles with in_valid = 0 do not advance the sequencing or the delay stages, and in_first is ignored in those cycles. out_valid rises exactly one cycle after the final sub-cycle of a column. out_lanes keep their value whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Array output lanes carry data this cycle |
| in_first | input | 1 | First input cycle of a new block |
| cfg_rows | input | 2 | Array row count: 00 four, 01 two, 10 one, 11 four |
| mode_2x2 | input | 1 | 1: two side-by-side 2x2 blocks; 0: one 4x4 block |
| in_lanes | input | 4*DW | Array output lanes, lane j at bits j*DW +: DW |
| out_valid | output | 1 | A transposed row is on out_lanes |
| out_lanes | output | 4*DW | Transposed lanes, lane k at bits k*DW +: DW |

## Verification
A first-of-block flag can arrive in the same cycle in which the column counter would otherwise be mid-column or about to wrap. The restart and the ordinary advance then compete for the same sequencing state. The bench provokes this in two ways. It abandons blocks part-way, both after a single sub-cycle in the two-row configuration and after two columns in the other configurations, and then restarts them with the flag. It also sends blocks back to back, some with the flag and some relying on the wrap. Each case is judged by whether the very next completed column carries the column-0 rotation with the new block's values and no stale lane from the abandoned one.

// File: rtl/xpose_pkg.sv
// Shared constants and configuration decoding for the lane transposer.
// Assumes a fixed four-lane array interface; data width is set on the top.
package xpose_pkg;

    localparam int LANES   = 4;
    localparam int MAX_DLY = 3;
    localparam int SEL_W   = $clog2(LANES);
    localparam int DLY_W   = $clog2(MAX_DLY + 1);
    localparam int SUB_W   = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        ROWS_FOUR = 2'b00,
        ROWS_TWO  = 2'b01,
        ROWS_ONE  = 2'b10,
        ROWS_RSVD = 2'b11
    } rows_cfg_e;

    // Number of input cycles that make up one column.
    function automatic logic [SUB_W-1:0] sub_count(input logic [1:0] cfg, input logic m2);
        case (cfg)
            ROWS_TWO: return m2 ? SUB_W'(1) : SUB_W'(2);
            ROWS_ONE: return m2 ? SUB_W'(2) : SUB_W'(4);
            default:  return SUB_W'(1);
        endcase
    endfunction

    // Extra delay stages a lane needs so that it lines up with the last lane of its column.
    function automatic logic [DLY_W-1:0] lane_delay(input logic [1:0] cfg, input logic m2,
                                                    input logic [SEL_W-1:0] lane);
        logic [SUB_W-1:0] arrive;
        case (cfg)
            ROWS_TWO: arrive = m2 ? SUB_W'(0) : SUB_W'(lane[1]);
            ROWS_ONE: arrive = m2 ? SUB_W'(lane[0]) : SUB_W'(lane);
            default:  arrive = SUB_W'(0);
        endcase
        return DLY_W'(sub_count(cfg, m2) - SUB_W'(1) - arrive);
    endfunction

endpackage

// File: rtl/xpose_seq.sv
// Column sequencer: tracks the sub-cycle within a column and the column
// within a block. It restarts on the first-of-block flag and wraps by itself.
// Assumes cfg and mode are held stable for the whole of a block.
module xpose_seq
    import xpose_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [1:0]       cfg,
    input  logic             m2,
    output logic             fire,
    output logic [SEL_W-1:0] beat
);

    logic [SUB_W-1:0] sub_q;
    logic [SEL_W-1:0] beat_q;
    logic [SUB_W-1:0] cur_sub;
    logic [SEL_W-1:0] cur_beat;
    logic [SUB_W-1:0] n_sub;
    logic             last_sub;
    logic             last_beat;

    // Pick the current position, forcing column 0 on a new block.
    always_comb begin
        n_sub     = sub_count(cfg, m2);
        cur_sub   = in_first ? '0 : sub_q;
        cur_beat  = in_first ? '0 : beat_q;
        last_sub  = (cur_sub == n_sub - SUB_W'(1));
        last_beat = (cur_beat == (m2 ? SEL_W'(1) : SEL_W'(LANES - 1)));
        fire      = in_valid && last_sub;
        beat      = cur_beat;
    end

    // Advance the position on each valid input cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            beat_q <= '0;
        end else if (in_valid) begin
            if (last_sub) begin
                sub_q  <= '0;
                beat_q <= last_beat ? '0 : cur_beat + SEL_W'(1);
            end else begin
                sub_q  <= cur_sub + SUB_W'(1);
                beat_q <= cur_beat;
            end
        end
    end

endmodule

// File: rtl/xpose_delay.sv
// Bypassable delay element for one lane. A short register chain shifts on
// valid input cycles only, and a tap selector picks the stage to use
// (0 means bypass).
module xpose_delay
    import xpose_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = MAX_DLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DW-1:0]    din,
    input  logic [DLY_W-1:0] sel,
    output logic [DW-1:0]    dout
);

    logic [DW-1:0] taps [0:DEPTH];

    // Stage 0 is the live input.
    always_comb taps[0] = din;

    for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
        // Each stage takes the previous one when the array presents data.
        always_ff @(posedge clk) begin
            if (!rst_n)  taps[s] <= '0;
            else if (en) taps[s] <= taps[s-1];
        end
    end

    // Select the tap that aligns this lane with the column's last lane.
    always_comb dout = taps[sel];

endmodule

// File: rtl/xpose_steer.sv
// Rotating lane selector. Upper lanes use 4:1 paths whose select narrows in
// 2x2 mode; lower lanes add a 2:1 path inside their own half for 2x2 mode.
// Assumes beat stays below 2 in 2x2 mode.
module xpose_steer
    import xpose_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]    aligned [LANES],
    input  logic [SEL_W-1:0] beat,
    input  logic             m2,
    output logic [DW-1:0]    steered [LANES]
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [SEL_W-1:0] K = SEL_W'(k);
        if (k < LANES / 2) begin : g_upper
            logic [SEL_W-1:0] sel;
            // Rotate over all lanes, or only within the upper half in 2x2 mode.
            always_comb begin
                sel        = m2 ? {1'b0, K[0] ^ beat[0]} : K - beat;
                steered[k] = aligned[sel];
            end
        end else begin : g_lower
            logic [DW-1:0] wide;
            logic [DW-1:0] narrow;
            // Full rotation path, then a half-local path, then mode choice.
            always_comb begin
                wide       = aligned[K - beat];
                narrow     = aligned[{1'b1, K[0] ^ beat[0]}];
                steered[k] = m2 ? narrow : wide;
            end
        end
    end

endmodule

// File: rtl/xpose_switch.sv
// Top of the lane transposer. It aligns the lanes of reduced-row arrays with
// per-lane delay chains, rotates each column into transposed lane order and
// registers the result. Latency is one cycle from the last sub-cycle of a
// column. Assumes cfg_rows and mode_2x2 are stable during a block.
module xpose_switch
    import xpose_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic [1:0]          cfg_rows,
    input  logic                mode_2x2,
    input  logic [LANES*DW-1:0] in_lanes,
    output logic                out_valid,
    output logic [LANES*DW-1:0] out_lanes
);

    logic             fire;
    logic [SEL_W-1:0] beat;
    logic [DW-1:0]    lane_in  [LANES];
    logic [DW-1:0]    aligned  [LANES];
    logic [DW-1:0]    steered  [LANES];

    xpose_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .cfg      (cfg_rows),
        .m2       (mode_2x2),
        .fire     (fire),
        .beat     (beat)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_align
        logic [DLY_W-1:0] dsel;
        // Unpack the lane and work out its alignment depth.
        always_comb begin
            lane_in[j] = in_lanes[j*DW +: DW];
            dsel       = lane_delay(cfg_rows, mode_2x2, SEL_W'(j));
        end

        xpose_delay #(.DW(DW), .DEPTH(MAX_DLY)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (lane_in[j]),
            .sel   (dsel),
            .dout  (aligned[j])
        );
    end

    xpose_steer #(.DW(DW)) u_steer (
        .aligned (aligned),
        .beat    (beat),
        .m2      (mode_2x2),
        .steered (steered)
    );

    // Register each completed column and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_lanes <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                for (int k = 0; k < LANES; k++) out_lanes[k*DW +: DW] <= steered[k];
            end
        end
    end

endmodule

// File: rtl/xpose_switch_chk.sv
// Protocol and timing checks for the lane transposer, attached by bind.
module xpose_switch_chk
    import xpose_pkg::*;
#(
    parameter int DW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_first,
    input logic [1:0]          cfg_rows,
    input logic                mode_2x2,
    input logic [LANES*DW-1:0] in_lanes,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_lanes
);

    // R10
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_lanes));

    // R2
    full_rows_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_rows == 2'b00 && !mode_2x2) |=> out_valid);

    // R3
    pair_mode_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_2x2 && (cfg_rows == 2'b00 || cfg_rows == 2'b01)) |=> out_valid);

    // R8
    first_column_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && cfg_rows == 2'b00) |=> (out_lanes == $past(in_lanes)));

    // R4
    two_rows_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && cfg_rows == 2'b01 && !mode_2x2) |=> !out_valid);

endmodule

bind xpose_switch xpose_switch_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .cfg_rows  (cfg_rows),
    .mode_2x2  (mode_2x2),
    .in_lanes  (in_lanes),
    .out_valid (out_valid),
    .out_lanes (out_lanes)
);

// File: tb/xpose_switch_tb.sv
`timescale 1ns/1ps
module xpose_switch_tb;

    localparam int DW = 16;
    localparam int NL = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_first = 1'b0;
    logic [1:0]      cfg_rows = 2'b00;
    logic            mode_2x2 = 1'b0;
    logic [NL*DW-1:0] in_lanes = '0;
    logic            out_valid;
    logic [NL*DW-1:0] out_lanes;

    int n_chk = 0;
    int n_fail = 0;
    logic [NL*DW-1:0] hold_val = '0;

    always #2.5 clk = ~clk;

    xpose_switch #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .cfg_rows(cfg_rows), .mode_2x2(mode_2x2), .in_lanes(in_lanes),
        .out_valid(out_valid), .out_lanes(out_lanes)
    );

    task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] yv(input int seed, input int r, input int c);
        return DW'(seed * 613 + r * 97 + c * 29 + r * c * 7 + 5);
    endfunction

    function automatic logic [DW-1:0] junk(input int seed, input int j, input int s);
        return DW'(16'hA5C0 ^ (seed << 5) ^ (j << 2) ^ s);
    endfunction

    function automatic int rows_of(input logic [1:0] cfg);
        return (cfg == 2'b01) ? 2 : (cfg == 2'b10) ? 1 : 4;
    endfunction

    function automatic int nsub_of(input logic [1:0] cfg, input bit m2);
        int r = rows_of(cfg);
        if (!m2) return 4 / r;
        return (r == 1) ? 2 : 1;
    endfunction

    function automatic int arrive(input logic [1:0] cfg, input bit m2, input int j);
        int r = rows_of(cfg);
        if (!m2) return j / r;
        return (r == 1) ? (j % 2) : 0;
    endfunction

    // Value carried by input lane j for column t (diagonal rotation).
    function automatic logic [DW-1:0] lane_val(input int seed, input bit m2, input int j, input int t);
        if (!m2) return yv(seed, (j + t) % 4, t);
        if (j < 2) return yv(seed, (j + t) % 2, t);
        return yv(seed, 2 + ((j - 2 + t) % 2), 2 + t);
    endfunction

    // Expected output lane k for column t (transposed order).
    function automatic logic [DW-1:0] exp_val(input int seed, input bit m2, input int k, input int t);
        if (!m2) return yv(seed, k, t);
        if (k < 2) return yv(seed, k, t);
        return yv(seed, k, 2 + t);
    endfunction

    function automatic string tag_of(input logic [1:0] cfg, input bit m2);
        int r = rows_of(cfg);
        if (m2) return (r == 1) ? "R6" : "R3";
        if (r == 2) return "R4";
        if (r == 1) return "R5";
        return (cfg == 2'b11) ? "R7" : "R2";
    endfunction

    task automatic send_block(input logic [1:0] cfg, input bit m2, input int seed, input bit first,
                              input int ncols, input bit gap, input string tag_ovr);
        int ns = nsub_of(cfg, m2);
        string tag = (tag_ovr != "") ? tag_ovr : tag_of(cfg, m2);
        for (int t = 0; t < ncols; t++) begin
            for (int s = 0; s < ns; s++) begin
                logic [NL*DW-1:0] v;
                logic [NL*DW-1:0] e;
                @(negedge clk);
                for (int j = 0; j < NL; j++)
                    v[j*DW +: DW] = (arrive(cfg, m2, j) == s) ? lane_val(seed, m2, j, t) : junk(seed, j, s);
                cfg_rows = cfg; mode_2x2 = m2; in_valid = 1'b1;
                in_first = first && t == 0 && s == 0;
                in_lanes = v;
                @(posedge clk); #1;
                if (s == ns - 1) begin
                    for (int k = 0; k < NL; k++) e[k*DW +: DW] = exp_val(seed, m2, k, t);
                    chk(tag, out_valid === 1'b1, 64'(out_valid), 64'd1);
                    chk(tag, out_lanes === e, out_lanes, e);
                    hold_val = e;
                end else begin
                    chk(tag, out_valid === 1'b0 && out_lanes === hold_val, out_lanes, hold_val);
                end
                if (gap) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_first = 1'b1; in_lanes = ~v;
                    @(posedge clk); #1;
                    // R10: idle cycle, flag ignored, output held
                    chk("R10", out_valid === 1'b0 && out_lanes === hold_val, out_lanes, hold_val);
                    in_first = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed = 1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", out_valid === 1'b0, 64'(out_valid), 64'd0);
        chk("R1", out_lanes === '0, out_lanes, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", out_valid === 1'b0 && out_lanes === '0, out_lanes, 64'd0);

        // Sweep every configuration and mode; second block relies on wrap (R9)
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                send_block(2'(c), 1'(m), seed, 1'b1, m ? 2 : 4, 1'(seed % 2), "");
                seed++;
                send_block(2'(c), 1'(m), seed, 1'b0, m ? 2 : 4, 1'b0, "R9");
                seed++;
            end
        end

        // R8: abandon a two-row block after one sub-cycle, then restart
        send_block(2'b01, 1'b0, seed, 1'b1, 1, 1'b0, "R8");
        seed++;
        @(negedge clk);
        cfg_rows = 2'b01; mode_2x2 = 1'b0; in_valid = 1'b1; in_first = 1'b1;
        for (int j = 0; j < NL; j++) in_lanes[j*DW +: DW] = junk(seed, j, 7);
        @(posedge clk); #1;
        chk("R8", out_valid === 1'b0 && out_lanes === hold_val, out_lanes, hold_val);
        send_block(2'b01, 1'b0, seed, 1'b1, 4, 1'b0, "R8");
        seed++;

        // R8: restart mid-block in each configuration
        for (int c = 0; c < 3; c++) begin
            send_block(2'(c), 1'b0, seed, 1'b1, 2, 1'b0, "");
            seed++;
            send_block(2'(c), 1'b0, seed, 1'b1, 4, 1'b0, "R8");
            seed++;
            send_block(2'(c), 1'b1, seed, 1'b1, 1, 1'b0, "");
            seed++;
            send_block(2'(c), 1'b1, seed, 1'b1, 2, 1'b1, "R8");
            seed++;
        end

        repeat (2) @(posedge clk);
        #1;
        chk("R10", out_valid === 1'b0 && out_lanes === hold_val, out_lanes, hold_val);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule